// File: doc/BRIEF.md
# Pseudo-Random Sequence Checker with Lock Tracking

This block watches a serial bit stream for a test sequence of maximal length. Three sources feed it: a whole unframed stream, a set of selected 8-bit timeslots, or the upper seven bits of those timeslots. The bits it takes may be inverted. It then locks a local shift-register generator onto the incoming sequence. Once locked, the local generator runs by itself, and every received bit that disagrees with it is reported as a one-cycle bit-error event.

Acquisition runs as a four-state machine. `ST_IDLE` waits for a rising edge on `test_en`; this is the transition *start*. `ST_LOAD` copies L received bits straight into the local register, where L is the register length of the chosen sequence; when L bits have been taken, the transition *loaded* leads on. `ST_VERIFY` then needs L further bits in a row that agree with the prediction; when they do, the transition *locked* leads on. A disagreement in `ST_VERIFY` takes the transition *retry* back to `ST_LOAD`. `ST_SYNC` is the locked state. Once locked, compared bits are grouped into back-to-back blocks of 48. If more than 10 errors fall in one block, the transition *lost* returns the machine to `ST_LOAD`. At any time, `test_en` low takes the transition *abort* to `ST_IDLE`.

Two sticky flags record any change of the lock status and any bit-error event. Each flag is cleared by a one-cycle clear pulse. The interrupt output is the OR of the flags whose enables are set.

Top module: `prbs_sync_detector`

## Requirements
- R1: `mode` picks the bits taken when `bit_valid` is high. 2'b00 takes every valid bit. 2'b01 and 2'b11 take only bits with `slot_sel` high. 2'b10 takes bits with `slot_sel` high and `bit_pos` not equal to 7; `bit_pos` 0 is the first, most significant bit of a timeslot. Bits that are not taken leave `sync` unchanged and raise no `err_evt`.
- R2: While `test_en` is low, the block stays idle with `sync` low and ignores all bits. Checking starts only on a 0-to-1 change of `test_en`.
- R3: `pat_sel` picks the sequence. 2'b00 selects length 2^11-1, with feedback x^11+x^9+1. 2'b01 selects 2^15-1, with x^15+x^14+1. 2'b10 and 2'b11 select 2^20-1, with x^20+x^17+1. A taken bit b(n) is expected to equal b(n-L) XOR b(n-T).
- R4: With `rx_inv` high, each taken bit is inverted before it is used. An inverted sequence then locks, and without `rx_inv` it never locks.
- R5: On an error-free stream, `sync` rises in the cycle after the 2L-th taken bit. A disagreement during `ST_VERIFY` restarts loading at the next taken bit.
- R6: While locked, each disagreeing taken bit gives exactly one `err_evt` pulse in the following cycle. Bits taken while not locked never give `err_evt`.
- R7: Compared bits after lock form back-to-back blocks of 48. The 11th error inside one block drops `sync` in the cycle after that bit. Errors split across two blocks with at most 10 in each keep the lock.
- R8: After loss of lock, acquisition restarts by itself, and `sync` rises again in the cycle after 2L further clean taken bits.
- R9: `chg_flag` is set by any change of `sync`, in either direction. `err_flag` is set by every `err_evt`. Each flag stays set until a one-cycle pulse on its clear input (`clr_chg`, `clr_err`).
- R10: `irq` is high exactly when (`err_flag` and `en_err_irq`) or (`chg_flag` and `en_chg_irq`).
- R11: After reset, `sync`, `err_evt`, `err_flag`, `chg_flag` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Checking enable; a rising edge starts acquisition |
| mode | input | 2 | Bit selection mode |
| pat_sel | input | 2 | Sequence selection |
| rx_inv | input | 1 | Invert taken bits |
| bit_valid | input | 1 | A stream bit is present this cycle |
| bit_in | input | 1 | Stream bit |
| slot_sel | input | 1 | Current timeslot is selected for test |
| bit_pos | input | 3 | Bit position within the timeslot, 0 first |
| en_err_irq | input | 1 | Interrupt enable for the bit-error flag |
| en_chg_irq | input | 1 | Interrupt enable for the lock-change flag |
| clr_err | input | 1 | Clear pulse for `err_flag` |
| clr_chg | input | 1 | Clear pulse for `chg_flag` |
| sync | output | 1 | Locked status |
| err_evt | output | 1 | One-cycle bit-error event |
| err_flag | output | 1 | Sticky bit-error flag |
| chg_flag | output | 1 | Sticky lock-change flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong state in the acquisition machine shows up as `sync` rising one or more taken bits early or late relative to the 2L count. It can also show as a lock that never forms on an inverted stream. The bench compares `sync` after every single taken bit, so such a fault is reported within the cycle it occurs. A miscounted error block shows as a lock lost one bit early on exactly 10 errors, or kept after the 11th error. A fault in the local generator's free-run shows as `err_evt` bursts on a clean locked stream, beginning at the first compared bit after lock.

// File: rtl/prbs_det_pkg.sv
package prbs_det_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_VERIFY = 2'd2,
        ST_SYNC   = 2'd3
    } det_state_e;

    localparam logic [1:0] MODE_ALL    = 2'b00;
    localparam logic [1:0] MODE_OCTET  = 2'b01;
    localparam logic [1:0] MODE_SEPTET = 2'b10;

    localparam logic [1:0] SEQ_SHORT = 2'b00;
    localparam logic [1:0] SEQ_MID   = 2'b01;

    // register length and second feedback tap of each sequence
    localparam int LEN_SHORT = 11;
    localparam int TAP_SHORT = 9;
    localparam int LEN_MID   = 15;
    localparam int TAP_MID   = 14;
    localparam int LEN_LONG  = 20;
    localparam int TAP_LONG  = 17;

    localparam int HIST_W = LEN_LONG;

endpackage

// File: rtl/prbs_bit_picker.sv
module prbs_bit_picker
    import prbs_det_pkg::*;
#(
    parameter int POS_W = 3
) (
    input  logic [1:0]       mode,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             rx_inv,
    input  logic             slot_sel,
    input  logic [POS_W-1:0] bit_pos,
    output logic             take,
    output logic             rx_bit
);

    localparam logic [POS_W-1:0] LAST_POS = '1;

    always_comb begin
        unique case (mode)
            MODE_ALL:    take = bit_valid;
            MODE_SEPTET: take = bit_valid & slot_sel & (bit_pos != LAST_POS);
            default:     take = bit_valid & slot_sel;
        endcase
        rx_bit = bit_in ^ rx_inv;
    end

endmodule

// File: rtl/prbs_ref_shift.sv
module prbs_ref_shift
    import prbs_det_pkg::*;
#(
    parameter int HW = HIST_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       shift,
    input  logic       feed,
    input  logic [1:0] pat_sel,
    output logic       pred
);

    logic [HW-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clear) begin
            hist_q <= '0;
        end else if (shift) begin
            hist_q <= {hist_q[HW-2:0], feed};
        end
    end

    // hist_q[0] holds the most recent bit
    always_comb begin
        unique case (pat_sel)
            SEQ_SHORT: pred = hist_q[LEN_SHORT-1] ^ hist_q[TAP_SHORT-1];
            SEQ_MID:   pred = hist_q[LEN_MID-1]   ^ hist_q[TAP_MID-1];
            default:   pred = hist_q[LEN_LONG-1]  ^ hist_q[TAP_LONG-1];
        endcase
    end

endmodule

// File: rtl/prbs_err_window.sv
module prbs_err_window #(
    parameter int WIN_LEN   = 48,
    parameter int ERR_LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic err,
    output logic lost
);

    localparam int BC_W = $clog2(WIN_LEN);
    localparam int EC_W = $clog2(ERR_LIMIT + 2);
    localparam logic [BC_W-1:0] BC_LAST  = BC_W'(WIN_LEN - 1);
    localparam logic [EC_W-1:0] EC_LIMIT = EC_W'(ERR_LIMIT);

    logic [BC_W-1:0] bit_cnt_q;
    logic [EC_W-1:0] err_cnt_q;

    assign lost = step & err & (err_cnt_q == EC_LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            err_cnt_q <= '0;
        end else if (clear) begin
            bit_cnt_q <= '0;
            err_cnt_q <= '0;
        end else if (step) begin
            if (bit_cnt_q == BC_LAST) begin
                bit_cnt_q <= '0;
                err_cnt_q <= '0;
            end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                if (err && err_cnt_q != EC_LIMIT) begin
                    err_cnt_q <= err_cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/prbs_flag_irq.sv
module prbs_flag_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic err_set,
    input  logic chg_set,
    input  logic clr_err,
    input  logic clr_chg,
    input  logic en_err,
    input  logic en_chg,
    output logic err_flag,
    output logic chg_flag,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            chg_flag <= 1'b0;
        end else begin
            err_flag <= err_set | (err_flag & ~clr_err);
            chg_flag <= chg_set | (chg_flag & ~clr_chg);
        end
    end

    assign irq = (err_flag & en_err) | (chg_flag & en_chg);

endmodule

// File: rtl/prbs_sync_detector.sv
module prbs_sync_detector
    import prbs_det_pkg::*;
#(
    parameter int POS_W     = 3,
    parameter int WIN_LEN   = 48,
    parameter int ERR_LIMIT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_en,
    input  logic [1:0]       mode,
    input  logic [1:0]       pat_sel,
    input  logic             rx_inv,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             slot_sel,
    input  logic [POS_W-1:0] bit_pos,
    input  logic             en_err_irq,
    input  logic             en_chg_irq,
    input  logic             clr_err,
    input  logic             clr_chg,
    output logic             sync,
    output logic             err_evt,
    output logic             err_flag,
    output logic             chg_flag,
    output logic             irq
);

    localparam int CNT_W = $clog2(HIST_W);

    det_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, last_idx;
    logic             test_en_q;
    logic             take, rx_bit, pred, match;
    logic             shift, feed, step, mism, lost;
    logic             sync_d, evt_d;

    prbs_bit_picker #(.POS_W(POS_W)) u_pick (
        .mode      (mode),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .rx_inv    (rx_inv),
        .slot_sel  (slot_sel),
        .bit_pos   (bit_pos),
        .take      (take),
        .rx_bit    (rx_bit)
    );

    prbs_ref_shift #(.HW(HIST_W)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q == ST_IDLE),
        .shift   (shift),
        .feed    (feed),
        .pat_sel (pat_sel),
        .pred    (pred)
    );

    prbs_err_window #(.WIN_LEN(WIN_LEN), .ERR_LIMIT(ERR_LIMIT)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != ST_SYNC),
        .step  (step),
        .err   (mism),
        .lost  (lost)
    );

    prbs_flag_irq u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_set  (evt_d),
        .chg_set  (sync_d != sync),
        .clr_err  (clr_err),
        .clr_chg  (clr_chg),
        .en_err   (en_err_irq),
        .en_chg   (en_chg_irq),
        .err_flag (err_flag),
        .chg_flag (chg_flag),
        .irq      (irq)
    );

    assign match = (rx_bit == pred);

    always_comb begin
        unique case (pat_sel)
            SEQ_SHORT: last_idx = CNT_W'(LEN_SHORT - 1);
            SEQ_MID:   last_idx = CNT_W'(LEN_MID - 1);
            default:   last_idx = CNT_W'(LEN_LONG - 1);
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            test_en_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            test_en_q <= test_en;
        end
    end

    // next state and datapath steering
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        shift   = 1'b0;
        feed    = rx_bit;
        step    = 1'b0;
        mism    = 1'b0;
        if (!test_en) begin
            state_d = ST_IDLE;                       // abort
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!test_en_q) begin            // start
                        state_d = ST_LOAD;
                        cnt_d   = '0;
                    end
                end
                ST_LOAD: begin
                    if (take) begin
                        shift = 1'b1;
                        if (cnt_q == last_idx) begin // loaded
                            state_d = ST_VERIFY;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_VERIFY: begin
                    if (take) begin
                        shift = 1'b1;
                        if (!match) begin            // retry
                            state_d = ST_LOAD;
                            cnt_d   = '0;
                        end else if (cnt_q == last_idx) begin // locked
                            state_d = ST_SYNC;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_SYNC: begin
                    if (take) begin
                        shift = 1'b1;
                        feed  = pred;                // free-running reference
                        step  = 1'b1;
                        mism  = !match;
                        if (lost) begin              // lost
                            state_d = ST_LOAD;
                            cnt_d   = '0;
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    assign sync_d = (state_d == ST_SYNC);
    assign evt_d  = step & mism;

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync    <= 1'b0;
            err_evt <= 1'b0;
        end else begin
            sync    <= sync_d;
            err_evt <= evt_d;
        end
    end

endmodule

// File: rtl/prbs_sync_detector_chk.sv
module prbs_sync_detector_chk #(
    parameter int POS_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             test_en,
    input logic             bit_valid,
    input logic             sync,
    input logic             err_evt,
    input logic             err_flag,
    input logic             chg_flag,
    input logic             irq
);

    // R2: no lock while checking is disabled
    a_r2_idle_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> !sync);

    // R1: a cycle with no stream bit changes nothing
    a_r1_no_bit_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && test_en) |=> ($stable(sync) && !err_evt));

    // R6: an error event only follows a locked cycle
    a_r6_err_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |-> $past(sync));

    // R9: every error event leaves the sticky flag set
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |-> err_flag);

    // R9: every lock change leaves the sticky flag set
    a_r9_chg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sync != $past(sync)) |-> chg_flag);

    // R7 R8: lock is lost only through an error or by disabling
    a_r7_loss_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync) |-> (err_evt || !$past(test_en)));

    // R10: no interrupt without a pending flag
    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (err_flag || chg_flag));

endmodule

bind prbs_sync_detector prbs_sync_detector_chk #(.POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_en   (test_en),
    .bit_valid (bit_valid),
    .sync      (sync),
    .err_evt   (err_evt),
    .err_flag  (err_flag),
    .chg_flag  (chg_flag),
    .irq       (irq)
);

// File: tb/tb_prbs_sync_detector.sv
module tb_prbs_sync_detector;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [1:0] pat_sel = 2'b00;
    logic       rx_inv = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       slot_sel = 1'b0;
    logic [2:0] bit_pos = 3'd0;
    logic       en_err_irq = 1'b0;
    logic       en_chg_irq = 1'b0;
    logic       clr_err = 1'b0;
    logic       clr_chg = 1'b0;
    logic       sync, err_evt, err_flag, chg_flag, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct packed { logic s; logic e; } exp_t;
    exp_t  sb_q[$];
    string tag_q[$];
    int    err_idx[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    prbs_sync_detector dut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .mode(mode),
        .pat_sel(pat_sel), .rx_inv(rx_inv), .bit_valid(bit_valid),
        .bit_in(bit_in), .slot_sel(slot_sel), .bit_pos(bit_pos),
        .en_err_irq(en_err_irq), .en_chg_irq(en_chg_irq),
        .clr_err(clr_err), .clr_chg(clr_chg), .sync(sync),
        .err_evt(err_evt), .err_flag(err_flag), .chg_flag(chg_flag),
        .irq(irq)
    );

    task automatic chk(input bit ok, input string tg, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tg, act, exp_v, $time);
        end
    endtask

    // monitor: pops one expectation per driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t  it;
                string tg;
                it = sb_q.pop_front();
                tg = tag_q.pop_front();
                chk(sync == it.s, {tg, " sync"}, int'(sync), int'(it.s));
                chk(err_evt == it.e, {tg, " R6 err_evt"}, int'(err_evt), int'(it.e));
            end
        end
    end

    function automatic int plen(input logic [1:0] p);
        return (p == 2'b00) ? 11 : (p == 2'b01) ? 15 : 20;
    endfunction
    function automatic int ptap(input logic [1:0] p);
        return (p == 2'b00) ? 9 : (p == 2'b01) ? 14 : 17;
    endfunction

    function automatic bit flip(input int k);
        foreach (err_idx[i]) if (err_idx[i] == k) return 1'b1;
        return 1'b0;
    endfunction

    // lock status expected after taken bit k
    function automatic bit synced(input int k, input int L, input int rs,
                                  input int la, input bit nv);
        int st;
        if (nv || k < 0) return 1'b0;
        st = ((rs < 0) ? 0 : rs + 1) + 2 * L - 1;
        if (k < st) return 1'b0;
        if (la < 0 || k < la) return 1'b1;
        return k >= la + 2 * L;
    endfunction

    // driver: one scenario of n taken bits
    task automatic stream(input logic [1:0] md, input logic [1:0] ps,
                          input bit inv_tx, input bit rinv, input int n,
                          input int rs, input int la, input bit nv,
                          input string tg);
        int L, T, k, c, vb;
        logic [19:0] g;
        bit taken, gb, b;
        exp_t it;
        L = plen(ps); T = ptap(ps); g = 20'h00ACE; k = 0; c = 0; vb = 0;
        @(negedge clk);
        test_en = 1'b0; bit_valid = 1'b0; mode = md; pat_sel = ps; rx_inv = rinv;
        @(negedge clk);
        test_en = 1'b1;
        while (k < n) begin
            @(negedge clk);
            bit_valid = (c % 7) != 3;
            c++;
            taken = 1'b0;
            if (bit_valid) begin
                bit_pos  = 3'(vb % 8);
                slot_sel = ((vb / 8) % 4 == 1) || ((vb / 8) % 4 == 3);
                vb++;
                taken = (md == 2'b00) || (slot_sel && (md != 2'b10 || bit_pos != 3'd7));
            end
            if (taken) begin
                gb = g[L-1] ^ g[T-1];
                g  = {g[18:0], gb};
                b  = gb ^ inv_tx ^ flip(k);
                it.e = flip(k) && synced(k - 1, L, rs, la, nv);
                it.s = synced(k, L, rs, la, nv);
                k++;
            end else begin
                b = 1'(vb);
                it.e = 1'b0;
                it.s = synced(k - 1, L, rs, la, nv);
            end
            bit_in = b;
            sb_q.push_back(it);
            tag_q.push_back(tg);
        end
        @(negedge clk);
        bit_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(sync == 1'b0, "R11 sync", int'(sync), 0);
        chk(err_evt == 1'b0, "R11 err_evt", int'(err_evt), 0);
        chk(err_flag == 1'b0 && chg_flag == 1'b0, "R11 flags", int'(err_flag | chg_flag), 0);
        chk(irq == 1'b0, "R11 irq", int'(irq), 0);
        rst_n = 1'b1;

        // R2: clean stream with checking disabled never locks
        begin
            logic [10:0] g;
            exp_t it;
            g = 11'h2CE;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                bit_valid = 1'b1;
                bit_in = g[10] ^ g[8];
                g = {g[9:0], g[10] ^ g[8]};
                it.s = 1'b0; it.e = 1'b0;
                sb_q.push_back(it);
                tag_q.push_back("R2");
            end
            @(negedge clk);
            bit_valid = 1'b0;
        end

        // R5 R3: short sequence, clean, unframed
        err_idx = {};
        stream(2'b00, 2'b00, 1'b0, 1'b0, 120, -1, -1, 1'b0, "R5 R3");
        // R5: mismatch during verify restarts acquisition
        err_idx = {15};
        stream(2'b00, 2'b00, 1'b0, 1'b0, 120, 15, -1, 1'b0, "R5 retry");

        // R6 R7: errors split across blocks, and exactly ten in one block
        err_idx = {};
        for (int i = 72; i < 84; i++) err_idx.push_back(i);
        for (int i = 130; i < 140; i++) err_idx.push_back(i);
        stream(2'b00, 2'b01, 1'b0, 1'b0, 200, -1, -1, 1'b0, "R7 keep");

        // R9 R10: sticky flags and interrupt
        @(negedge clk);
        chk(err_flag == 1'b1, "R9 err_flag set", int'(err_flag), 1);
        chk(chg_flag == 1'b1, "R9 chg_flag set", int'(chg_flag), 1);
        chk(irq == 1'b0, "R10 irq masked", int'(irq), 0);
        en_err_irq = 1'b1;
        #1 chk(irq == 1'b1, "R10 irq err", int'(irq), 1);
        en_err_irq = 1'b0; en_chg_irq = 1'b1;
        #1 chk(irq == 1'b1, "R10 irq chg", int'(irq), 1);
        @(negedge clk);
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
        chk(err_flag == 1'b0, "R9 err_flag clear", int'(err_flag), 0);
        chk(chg_flag == 1'b1, "R9 chg_flag kept", int'(chg_flag), 1);
        clr_chg = 1'b1;
        @(negedge clk);
        clr_chg = 1'b0;
        chk(chg_flag == 1'b0, "R9 chg_flag clear", int'(chg_flag), 0);
        chk(irq == 1'b0, "R10 irq cleared", int'(irq), 0);
        test_en = 1'b0;
        @(negedge clk);
        chk(sync == 1'b0, "R2 sync on disable", int'(sync), 0);
        chk(chg_flag == 1'b1, "R9 chg_flag on fall", int'(chg_flag), 1);
        chk(irq == 1'b1, "R10 irq on fall", int'(irq), 1);
        en_chg_irq = 1'b0;

        // R7 R8: eleven errors in one block, then automatic relock
        err_idx = {};
        for (int i = 50; i < 61; i++) err_idx.push_back(i);
        stream(2'b00, 2'b10, 1'b0, 1'b0, 160, -1, 60, 1'b0, "R7 R8 loss");

        // R1: framed selections
        err_idx = {};
        stream(2'b01, 2'b00, 1'b0, 1'b0, 80, -1, -1, 1'b0, "R1 octet");
        stream(2'b10, 2'b01, 1'b0, 1'b0, 80, -1, -1, 1'b0, "R1 septet");
        stream(2'b11, 2'b11, 1'b0, 1'b0, 80, -1, -1, 1'b0, "R1 R3 mode3");

        // R4: receive inversion
        stream(2'b00, 2'b00, 1'b1, 1'b1, 60, -1, -1, 1'b0, "R4 inverted");
        stream(2'b00, 2'b00, 1'b1, 1'b0, 60, -1, -1, 1'b1, "R4 no lock");

        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule